// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block paces the measurement activity of a two-channel temperature monitor. It runs conversion cycles made of two fixed-length slots, first the on-die (local) channel and then the external diode (remote) channel. At the end of each slot it latches that channel's sample into a result register and emits a one-cycle done strobe that carries a channel tag. A timing prescaler divides the system clock into ticks. Every slot lasts a fixed number of ticks. A rate code then sets how many idle ticks follow a cycle, so the conversion itself never gets longer or shorter with the rate.

The remote path corrects each raw sample by adding a signed offset, given as whole degrees plus three fraction bits, and saturates the sum to the 11-bit result range. Diode faults bypass that path: an open or supply-tied diode stores a fixed hottest code and raises an open flag, and a diode shorted to ground stores a fixed coldest code. A shutdown input stops new cycles from starting. While in shutdown, a one-shot write pulse asks for exactly one extra cycle. The analog converter sits outside the block and is seen only as sample inputs with two fault flags.

Top module: `conv_sched`

## Requirements
- R1: Out of reset, `local_temp_o`, `remote_hi_o`, `remote_lo_o`, `open_o`, `done_o` and `busy_o` are all 0, and the result registers stay 0 until the first slot that stores them ends.
- R2: A cycle is a local slot followed by a remote slot, each SLOT_TICKS ticks long. The end of each slot produces a one-cycle `done_o` pulse. `done_chan_o` is 0 for local and 1 for remote, and it holds its last value between pulses.
- R3: `busy_o` is 1 exactly while a local or remote slot is running. It falls only in the cycle that reports a remote result.
- R4: When not in shutdown, the end of one remote slot is followed by the end of the next after max(2·SLOT_TICKS, FAST_PERIOD_TICKS·2^(9−code)) ticks. The rate code is sampled when a remote slot ends, and the slot length does not depend on the code.
- R5: Rate codes 10 to 15 behave exactly like code 9, the fastest rate.
- R6: While `shutdown_i` is 1, no new cycle starts on its own. A cycle already running completes both slots.
- R7: A one-cycle `oneshot_wr_i` pulse while `shutdown_i` is 1 starts exactly one cycle at the next tick boundary once the block is idle. The same pulse while `shutdown_i` is 0 has no effect.
- R8: A remote result equals the 11-bit two's-complement sample plus the offset {`offset_int_i`,`offset_frac_i`}, in units of 1/8 degree, saturated to −1024..+1023. `remote_hi_o` holds bits 10:3 of the result, `remote_lo_o[7:5]` holds bits 2:0, and `remote_lo_o[4:0]` is 0.
- R9: If `diode_open_i` is 1 when a remote slot ends, the stored result is hi 0x7F, lo 0x00 and `open_o` is 1. This wins over `diode_short_i`.
- R10: If only `diode_short_i` is 1 when a remote slot ends, the stored result is hi 0x80, lo 0x00 and `open_o` is 0. The offset is not applied to either fault code.
- R11: `local_temp_o` takes `local_sample_i` unchanged at the end of each local slot and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_code_i | input | 4 | Rate code, sampled at each remote slot end |
| shutdown_i | input | 1 | 1 blocks new cycles from starting |
| oneshot_wr_i | input | 1 | One-cycle single-cycle request, used only in shutdown |
| offset_int_i | input | 8 | Signed offset, whole degrees |
| offset_frac_i | input | 3 | Offset fraction, 1/8 degree units |
| local_sample_i | input | 8 | Local converter sample, signed degrees |
| remote_sample_i | input | 11 | Remote converter sample, signed 1/8 degree |
| diode_open_i | input | 1 | Remote diode open or tied to supply |
| diode_short_i | input | 1 | Remote diode shorted to ground |
| busy_o | output | 1 | A conversion slot is running |
| done_o | output | 1 | One-cycle result strobe |
| done_chan_o | output | 1 | Channel of the latest strobe, 1 = remote |
| local_temp_o | output | 8 | Local result |
| remote_hi_o | output | 8 | Remote result, whole-degree byte |
| remote_lo_o | output | 8 | Remote result, fraction in bits 7:5 |
| open_o | output | 1 | Open-diode flag of the latest remote result |

## Verification
The interesting coincidence is a remote slot ending in the same cycle that the start decision for the next cycle is made. At the fastest rate these two events fall together as a back-to-back restart, and the value of `shutdown_i` in that cycle decides whether the block keeps going or stops. The bench changes the rate between 7, 8, 9 and 12 and raises shutdown while cycles are running. A behavioural reference, compared on every clock, checks that `busy_o` either stays high or falls together with the remote strobe, and that one-shot requests made while a cycle is running are honoured only after it. Directed checks measure the spacing between remote strobes and count strobes inside shutdown windows.

// File: rtl/cs_pkg.sv
// Package cs_pkg: types and constants shared by the conversion scheduler.
// Assumes the rate code space is 0..RATE_MAX, and every code above it maps to RATE_MAX.
package cs_pkg;
    // fastest defined rate code; each lower code doubles the period
    localparam int RATE_MAX = 9;

    // sequencer phase
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_LOCAL  = 2'd1,
        ST_REMOTE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/cs_tick_gen.sv
// Module cs_tick_gen: divides the clock into a one-cycle tick every TICK_CYCLES cycles.
// Assumes TICK_CYCLES >= 1; the first tick comes TICK_CYCLES-1 cycles after reset.
module cs_tick_gen #(
    parameter int TICK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (TICK_CYCLES <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int TW = $clog2(TICK_CYCLES);
            localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);
            logic [TW-1:0] div_q;

            // free-running divider counter
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + TW'(1);
                end
            end

            assign tick_o = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/cs_rate_table.sv
// Module cs_rate_table: maps a rate code to the idle ticks that follow one conversion cycle.
// Assumes period(code) = FAST_PERIOD_TICKS * 2^(RATE_MAX-code), and the idle time is the
// period minus the conversion time, never below zero.
module cs_rate_table
    import cs_pkg::*;
#(
    parameter int RATE_W            = 4,
    parameter int SLOT_TICKS        = 4,
    parameter int FAST_PERIOD_TICKS = 8,
    parameter int CW                = 13
) (
    input  logic [RATE_W-1:0] rate_code_i,
    output logic [CW-1:0]     idle_ticks_o
);
    localparam int ENTRIES    = 1 << RATE_W;
    localparam int CONV_TICKS = 2 * SLOT_TICKS;

    logic [CW-1:0] gap_tab [ENTRIES];

    // one constant entry per code; codes past RATE_MAX copy the fastest entry
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_rate
            localparam int EFF = (g > RATE_MAX) ? RATE_MAX : g;
            localparam int PER = FAST_PERIOD_TICKS * (1 << (RATE_MAX - EFF));
            localparam int GAP = (PER > CONV_TICKS) ? (PER - CONV_TICKS) : 0;
            assign gap_tab[g] = CW'(GAP);
        end
    endgenerate

    assign idle_ticks_o = gap_tab[rate_code_i];
endmodule

// File: rtl/cs_remote_fix.sv
// Module cs_remote_fix: turns a raw remote sample into the stored byte pair.
// Assumes the sample and offset are two's complement in 1/FRAC units. A fault replaces the
// sum with a fixed code, and an open diode wins over a short.
module cs_remote_fix #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 3
) (
    input  logic [INT_W+FRAC_W-1:0] sample_i,
    input  logic [INT_W-1:0]        off_int_i,
    input  logic [FRAC_W-1:0]       off_frac_i,
    input  logic                    open_i,
    input  logic                    short_i,
    output logic [INT_W-1:0]        hi_o,
    output logic [INT_W-1:0]        lo_o,
    output logic                    open_flag_o
);
    localparam int REM_W = INT_W + FRAC_W;
    localparam int PAD_W = INT_W - FRAC_W;
    localparam logic [REM_W-1:0] POS_MAX  = {1'b0, {(REM_W-1){1'b1}}};
    localparam logic [REM_W-1:0] NEG_MIN  = {1'b1, {(REM_W-1){1'b0}}};
    localparam logic [INT_W-1:0] HOT_CODE = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] COLD_CODE = {1'b1, {(INT_W-1){1'b0}}};

    logic [REM_W-1:0] off_w;
    logic [REM_W:0]   sum_w;
    logic [REM_W-1:0] sat_w;

    // sign-extended add of offset to the sample
    always_comb begin
        off_w = {off_int_i, off_frac_i};
        sum_w = {sample_i[REM_W-1], sample_i} + {off_w[REM_W-1], off_w};
    end

    // clamp on signed overflow
    always_comb begin
        if (sum_w[REM_W] != sum_w[REM_W-1]) begin
            sat_w = sum_w[REM_W] ? NEG_MIN : POS_MAX;
        end else begin
            sat_w = sum_w[REM_W-1:0];
        end
    end

    // fault substitution and byte split
    always_comb begin
        if (open_i) begin
            hi_o        = HOT_CODE;
            lo_o        = '0;
            open_flag_o = 1'b1;
        end else if (short_i) begin
            hi_o        = COLD_CODE;
            lo_o        = '0;
            open_flag_o = 1'b0;
        end else begin
            hi_o        = sat_w[REM_W-1:FRAC_W];
            lo_o        = {sat_w[FRAC_W-1:0], {PAD_W{1'b0}}};
            open_flag_o = 1'b0;
        end
    end
endmodule

// File: rtl/cs_seq.sv
// Module cs_seq: steps through the wait, local and remote phases on prescaler ticks.
// Assumes idle_ticks_i is valid in the cycle a remote slot ends. A zero idle time with no
// shutdown goes straight back to the local slot, so the cycle period is exactly
// conversion plus idle.
module cs_seq
    import cs_pkg::*;
#(
    parameter int SLOT_TICKS = 4,
    parameter int CW         = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          shutdown_i,
    input  logic          oneshot_wr_i,
    input  logic [CW-1:0] idle_ticks_i,
    output logic          busy_o,
    output logic          end_local_o,
    output logic          end_remote_o
);
    localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_TICKS - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pend_q, pend_d;
    logic          start_w;

    // next-state and slot/gap counter logic, advanced only on ticks
    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        start_w      = 1'b0;
        end_local_o  = 1'b0;
        end_remote_o = 1'b0;
        if (tick_i) begin
            case (state_q)
                ST_WAIT: begin
                    if ((cnt_q == '0 && !shutdown_i) || (shutdown_i && pend_q)) begin
                        start_w = 1'b1;
                        state_d = ST_LOCAL;
                        cnt_d   = SLOT_LAST;
                    end else if (cnt_q != '0) begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
                ST_LOCAL: begin
                    if (cnt_q == '0) begin
                        end_local_o = 1'b1;
                        state_d     = ST_REMOTE;
                        cnt_d       = SLOT_LAST;
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
                ST_REMOTE: begin
                    if (cnt_q == '0) begin
                        end_remote_o = 1'b1;
                        if (idle_ticks_i == '0 && !shutdown_i) begin
                            state_d = ST_LOCAL;
                            cnt_d   = SLOT_LAST;
                        end else begin
                            state_d = ST_WAIT;
                            cnt_d   = (idle_ticks_i == '0) ? '0 : (idle_ticks_i - CW'(1));
                        end
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
                default: begin
                    state_d = ST_WAIT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // one-shot request latch: armed only in shutdown, consumed by a start
    always_comb begin
        if (start_w || !shutdown_i) begin
            pend_d = 1'b0;
        end else if (oneshot_wr_i) begin
            pend_d = 1'b1;
        end else begin
            pend_d = pend_q;
        end
    end

    // sequencer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    assign busy_o = (state_q != ST_WAIT);
endmodule

// File: rtl/conv_sched.sv
// Module conv_sched: top of the conversion scheduler. It pairs the sequencer with the
// rate table, the prescaler and the remote correction, and holds the result registers.
// Assumes converter samples are valid in the cycle a slot ends and FRAC_W <= INT_W.
module conv_sched
    import cs_pkg::*;
#(
    parameter int TICK_CYCLES       = 4,
    parameter int SLOT_TICKS        = 4,
    parameter int FAST_PERIOD_TICKS = 8,
    parameter int RATE_W            = 4,
    parameter int INT_W             = 8,
    parameter int FRAC_W            = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [RATE_W-1:0]       rate_code_i,
    input  logic                    shutdown_i,
    input  logic                    oneshot_wr_i,
    input  logic [INT_W-1:0]        offset_int_i,
    input  logic [FRAC_W-1:0]       offset_frac_i,
    input  logic [INT_W-1:0]        local_sample_i,
    input  logic [INT_W+FRAC_W-1:0] remote_sample_i,
    input  logic                    diode_open_i,
    input  logic                    diode_short_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    done_chan_o,
    output logic [INT_W-1:0]        local_temp_o,
    output logic [INT_W-1:0]        remote_hi_o,
    output logic [INT_W-1:0]        remote_lo_o,
    output logic                    open_o
);
    localparam int MAX_PERIOD = FAST_PERIOD_TICKS * (1 << RATE_MAX);
    localparam int CNT_TOP    = (MAX_PERIOD > SLOT_TICKS) ? MAX_PERIOD : SLOT_TICKS;
    localparam int CW         = $clog2(CNT_TOP + 1);

    logic          tick_w;
    logic [CW-1:0] idle_w;
    logic          end_local_w, end_remote_w;
    logic [INT_W-1:0] fix_hi_w, fix_lo_w;
    logic          fix_open_w;

    cs_tick_gen #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    cs_rate_table #(
        .RATE_W            (RATE_W),
        .SLOT_TICKS        (SLOT_TICKS),
        .FAST_PERIOD_TICKS (FAST_PERIOD_TICKS),
        .CW                (CW)
    ) u_rate (
        .rate_code_i  (rate_code_i),
        .idle_ticks_o (idle_w)
    );

    cs_seq #(
        .SLOT_TICKS (SLOT_TICKS),
        .CW         (CW)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_w),
        .shutdown_i   (shutdown_i),
        .oneshot_wr_i (oneshot_wr_i),
        .idle_ticks_i (idle_w),
        .busy_o       (busy_o),
        .end_local_o  (end_local_w),
        .end_remote_o (end_remote_w)
    );

    cs_remote_fix #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_fix (
        .sample_i    (remote_sample_i),
        .off_int_i   (offset_int_i),
        .off_frac_i  (offset_frac_i),
        .open_i      (diode_open_i),
        .short_i     (diode_short_i),
        .hi_o        (fix_hi_w),
        .lo_o        (fix_lo_w),
        .open_flag_o (fix_open_w)
    );

    // done strobe and channel tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            done_chan_o <= 1'b0;
        end else begin
            done_o <= end_local_w | end_remote_w;
            if (end_remote_w) begin
                done_chan_o <= 1'b1;
            end else if (end_local_w) begin
                done_chan_o <= 1'b0;
            end
        end
    end

    // local result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_temp_o <= '0;
        end else if (end_local_w) begin
            local_temp_o <= local_sample_i;
        end
    end

    // remote result registers and open flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remote_hi_o <= '0;
            remote_lo_o <= '0;
            open_o      <= 1'b0;
        end else if (end_remote_w) begin
            remote_hi_o <= fix_hi_w;
            remote_lo_o <= fix_lo_w;
            open_o      <= fix_open_w;
        end
    end
endmodule

// File: rtl/conv_sched_chk.sv
// Module conv_sched_chk: temporal checks on the scheduler ports, bound into conv_sched.
// Assumes the synchronous active-low reset of the top.
module conv_sched_chk #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic             done_chan_o,
    input logic [INT_W-1:0] local_temp_o,
    input logic [INT_W-1:0] remote_hi_o,
    input logic [INT_W-1:0] remote_lo_o,
    input logic             open_o
);
    localparam int PAD_W = INT_W - FRAC_W;

    // R3
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && done_chan_o));

    // R2
    local_done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !done_chan_o) |-> busy_o);

    // R9
    open_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |-> (remote_hi_o == {1'b0, {(INT_W-1){1'b1}}} && remote_lo_o == '0));

    // R11
    local_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && !done_chan_o) |-> $stable(local_temp_o));

    // R8
    remote_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && done_chan_o) |-> ($stable(remote_hi_o) && $stable(remote_lo_o) && $stable(open_o)));

    // R8
    lo_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remote_lo_o[PAD_W-1:0] == '0);
endmodule

bind conv_sched conv_sched_chk #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .done_chan_o  (done_chan_o),
    .local_temp_o (local_temp_o),
    .remote_hi_o  (remote_hi_o),
    .remote_lo_o  (remote_lo_o),
    .open_o       (open_o)
);

// File: tb/conv_sched_tb_top.sv
// Bench for conv_sched: a behavioural reference compared every clock, plus directed checks.
module conv_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK   = 4;
    localparam int SLOT   = 4;
    localparam int FAST   = 8;
    localparam int WDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rate_code;
    logic        shutdown, oneshot;
    logic [7:0]  off_int;
    logic [2:0]  off_frac;
    logic [7:0]  local_s;
    logic [10:0] remote_s;
    logic        d_open, d_short;
    logic        busy_o, done_o, done_chan_o, open_o;
    logic [7:0]  local_temp_o, remote_hi_o, remote_lo_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    conv_sched dut_i (
        .clk (clk), .rst_n (rst_n), .rate_code_i (rate_code), .shutdown_i (shutdown),
        .oneshot_wr_i (oneshot), .offset_int_i (off_int), .offset_frac_i (off_frac),
        .local_sample_i (local_s), .remote_sample_i (remote_s), .diode_open_i (d_open),
        .diode_short_i (d_short), .busy_o (busy_o), .done_o (done_o), .done_chan_o (done_chan_o),
        .local_temp_o (local_temp_o), .remote_hi_o (remote_hi_o), .remote_lo_o (remote_lo_o),
        .open_o (open_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int idle_of(input int code);
        int c = (code > 9) ? 9 : code;
        int per = FAST * (2 ** (9 - c));
        return (per > 2 * SLOT) ? per - 2 * SLOT : 0;
    endfunction

    // reference model state
    int m_pc, m_phase, m_left, m_pend, m_done, m_chan, m_local, m_rhi, m_rlo, m_open;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (!rst_n) begin
            m_pc = 0; m_phase = 0; m_left = 0; m_pend = 0; m_done = 0;
            m_chan = 0; m_local = 0; m_rhi = 0; m_rlo = 0; m_open = 0;
        end else begin
            bit tk, go;
            tk = (m_pc == TICK - 1);
            m_pc = tk ? 0 : m_pc + 1;
            m_done = 0;
            go = 0;
            if (tk) begin
                if (m_phase == 0) begin
                    if ((m_left == 0 && !shutdown) || (shutdown && m_pend != 0)) begin
                        m_phase = 1; m_left = SLOT - 1; go = 1;
                    end else if (m_left > 0) m_left--;
                end else if (m_phase == 1) begin
                    if (m_left == 0) begin
                        m_local = local_s; m_done = 1; m_chan = 0;
                        m_phase = 2; m_left = SLOT - 1;
                    end else m_left--;
                end else begin
                    if (m_left == 0) begin
                        int gap;
                        m_done = 1; m_chan = 1;
                        if (d_open) begin
                            m_rhi = 127; m_rlo = 0; m_open = 1;
                        end else if (d_short) begin
                            m_rhi = 128; m_rlo = 0; m_open = 0;
                        end else begin
                            int s, o;
                            s = remote_s; if (s >= 1024) s -= 2048;
                            o = {off_int, off_frac}; if (o >= 1024) o -= 2048;
                            s = s + o;
                            if (s > 1023) s = 1023;
                            if (s < -1024) s = -1024;
                            m_rhi = (s >>> 3) & 255;
                            m_rlo = (s & 7) << 5;
                            m_open = 0;
                        end
                        gap = idle_of(rate_code);
                        if (gap == 0 && !shutdown) begin
                            m_phase = 1; m_left = SLOT - 1;
                        end else begin
                            m_phase = 0; m_left = (gap == 0) ? 0 : gap - 1;
                        end
                    end else m_left--;
                end
            end
            if (go || !shutdown) m_pend = 0;
            else if (oneshot) m_pend = 1;
        end
    end

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        chk("R3 busy", busy_o, (m_phase != 0) ? 1 : 0);
        chk("R2 done", done_o, m_done);
        chk("R2 chan", done_chan_o, m_chan);
        chk("R11 local", local_temp_o, m_local);
        chk("R8 rhi", remote_hi_o, m_rhi);
        chk("R8 rlo", remote_lo_o, m_rlo);
        chk("R9 open", open_o, m_open);
    end

    task automatic at_drive();
        @(posedge clk); #1;
    endtask

    task automatic wait_rdone(output int t);
        do @(negedge clk); while (!(done_o && done_chan_o));
        t = cyc;
    endtask

    task automatic count_done(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge clk); if (done_o) c++; end
    endtask

    initial begin
        int t0, t1, c;
        rst_n = 0; rate_code = 4'd8; shutdown = 0; oneshot = 0;
        off_int = 0; off_frac = 0; local_s = 8'h19; remote_s = 11'd200;
        d_open = 0; d_short = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset local", local_temp_o, 0);
        chk("R1 reset rhi", remote_hi_o, 0);
        chk("R1 reset busy", busy_o, 0);
        chk("R1 reset done", done_o, 0);
        at_drive(); rst_n = 1;
        // R1 nothing stored before the first local slot ends
        repeat (6) @(negedge clk);
        chk("R1 pre-conversion local", local_temp_o, 0);

        wait_rdone(t0);
        chk("R11 local stored", local_temp_o, 8'h19);
        chk("R8 plain remote hi", remote_hi_o, 8'h19);

        // R4 spacing at code 8
        wait_rdone(t0); wait_rdone(t1);
        chk("R4 period code 8", t1 - t0, 16 * TICK);
        at_drive(); rate_code = 4'd9;
        wait_rdone(t0); wait_rdone(t0); wait_rdone(t1);
        chk("R4 period code 9", t1 - t0, 8 * TICK);
        at_drive(); rate_code = 4'd12;
        wait_rdone(t0); wait_rdone(t0); wait_rdone(t1);
        chk("R5 code 12 as 9", t1 - t0, 8 * TICK);
        at_drive(); rate_code = 4'd7;
        wait_rdone(t0); wait_rdone(t0); wait_rdone(t1);
        chk("R4 period code 7", t1 - t0, 32 * TICK);
        at_drive(); rate_code = 4'd9;
        wait_rdone(t0);

        // R8 offset, fraction and saturation
        at_drive(); remote_s = 11'd200; off_int = 8'hFF; off_frac = 3'd0;
        wait_rdone(t0);
        chk("R8 neg offset hi", remote_hi_o, 8'h18);
        chk("R8 neg offset lo", remote_lo_o, 0);
        at_drive(); remote_s = 11'd203; off_int = 8'h00; off_frac = 3'd2;
        wait_rdone(t0);
        chk("R8 frac hi", remote_hi_o, 8'h19);
        chk("R8 frac lo", remote_lo_o, 8'hA0);
        at_drive(); remote_s = 11'd1000; off_int = 8'h0C; off_frac = 3'd0;
        wait_rdone(t0);
        chk("R8 sat high hi", remote_hi_o, 8'h7F);
        chk("R8 sat high lo", remote_lo_o, 8'hE0);
        at_drive(); remote_s = 11'(2048 - 1000); off_int = 8'hF4; off_frac = 3'd0;
        local_s = 8'hC9;
        wait_rdone(t0);
        chk("R8 sat low hi", remote_hi_o, 8'h80);
        chk("R8 sat low open", open_o, 0);
        chk("R11 negative local", local_temp_o, 8'hC9);

        // R9 / R10 faults
        at_drive(); d_open = 1;
        wait_rdone(t0);
        chk("R9 open hi", remote_hi_o, 8'h7F);
        chk("R9 open flag", open_o, 1);
        at_drive(); d_short = 1;
        wait_rdone(t0);
        chk("R9 open wins hi", remote_hi_o, 8'h7F);
        at_drive(); d_open = 0;
        wait_rdone(t0);
        chk("R10 short hi", remote_hi_o, 8'h80);
        chk("R10 short lo", remote_lo_o, 0);
        chk("R10 short flag", open_o, 0);
        at_drive(); d_short = 0;

        // R6 shutdown: running cycle completes, then nothing starts
        repeat (5) @(posedge clk);
        #1 shutdown = 1;
        wait_rdone(t0);
        count_done(400, c);
        chk("R6 no cycles in shutdown", c, 0);
        chk("R6 idle in shutdown", busy_o, 0);

        // R7 one-shot in shutdown gives one cycle
        at_drive(); oneshot = 1;
        at_drive(); oneshot = 0;
        count_done(200, c);
        chk("R7 one-shot strobes", c, 2);

        // R7 one-shot outside shutdown ignored (long gap at code 0)
        at_drive(); rate_code = 4'd0; shutdown = 0;
        wait_rdone(t0);
        at_drive(); oneshot = 1;
        at_drive(); oneshot = 0;
        count_done(3000, c);
        chk("R7 one-shot ignored when running", c, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule